// File: doc/BRIEF.md
# Role-Based Register Access Checker

This block sits in front of a small bank of eight 32-bit peripheral registers and decides, for every bus request, whether the requesting role may perform that read or write on the addressed register. Each request presents a role number, a register index, a read/write flag and write data. The checker looks the request up in a fixed grant matrix, gated by a role-enable mask that boot code sets once. Accesses that are allowed reach the bank. Accesses that are refused have no effect: a refused read returns zero, and a refused write changes nothing. A refusal is reported with a one-cycle error flag on the response, and it also latches a violation flag that stays set.

The bank holds the access mask word, a key-manager group (key control, key-valid and key-clear), two configuration words and two data-buffer words. The key-manager group and the mask word are the sensitive registers. While the tamper input is high, every access to them is refused. Every request gets its response exactly one cycle later, whatever the outcome.

Top module: `regacc_guard`

## Requirements
- R1: Roles are numbered 0 boot, 1 trusted firmware, 2 untrusted firmware, 3 debug, 4 DMA. Values 5 to 7 are refused on every register. A known role reaches a register only where its grant bit is set; for example, debug may write configuration index 5 and untrusted may read it.
- R2: A refused read responds with `rsp_err`=1 and `rsp_rdata`=0. A granted request responds with `rsp_err`=0.
- R3: A refused write leaves every register unchanged, as seen by a later granted read.
- R4: In the key group (index 1 key control, 2 key valid, 3 key clear), boot may write all three and may read indices 1 and 2. Trusted firmware may read index 2 only and may not write index 1. Untrusted firmware has no access to indices 1 to 3.
- R5: The DMA role may read and write only the data-buffer indices 6 and 7. It is refused on the configuration indices 4 and 5.
- R6: Index 0 holds a role-enable mask, with bit r enabling role r, and resets to 5'b00001. Only boot may write it, and only the first such write after reset takes effect. Later writes are refused. Boot and trusted firmware may read it.
- R7: While `tamper` is 1, every access to indices 0 to 3 is refused. Indices 4 to 7 are unaffected.
- R8: `rsp_valid` is 1 exactly one cycle after each cycle in which `req_valid` is 1, and 0 otherwise, for granted and refused requests alike.
- R9: `violation` becomes 1 in the cycle of the first refused response and stays 1 until reset.
- R10: A granted write to index 3 with bit 0 set clears key control and key valid to zero. Index 3 stores nothing and is readable by no role.
- R11: After reset, `rsp_valid`, `rsp_err`, `violation`, `key_ctrl` and `key_valid` are 0, and all data registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_role | input | 3 | Requester role number |
| req_addr | input | 3 | Register index |
| req_wdata | input | 32 | Write data |
| tamper | input | 1 | Tamper alarm; revokes access to sensitive registers |
| rsp_valid | output | 1 | Response present, one cycle after request |
| rsp_err | output | 1 | Response is a refusal |
| rsp_rdata | output | 32 | Read data, zero when refused or for writes |
| violation | output | 1 | Sticky refusal indicator |
| key_ctrl | output | 32 | Current key control word |
| key_valid | output | 32 | Current key valid word |

## Verification
The properties assume the role number, index and flags are steady in the cycle `req_valid` is sampled. They also assume that `tamper` and the request are judged at the same edge. The bench drives every input on the falling edge and holds it through the next rising edge, so each request sees one stable tamper value. The key-control property assumes that only a boot write to index 1 or 3 may move that word. The stimulus includes refused writes from other roles, and from boot while tamper is high, to challenge that assumption.

// File: rtl/regacc_pkg.sv
// Shared constants for the role-based register access checker.
// Assumes an eight-entry bank and five known roles; grant rows are
// indexed by register, with one bit per role (bit r = role r).
package regacc_pkg;
    localparam int ROLE_W = 3;
    localparam int NROLE  = 5;
    localparam int ADDR_W = 3;
    localparam int NREG   = 1 << ADDR_W;
    localparam int N_SENS = 4;          // indices below this are sensitive
    localparam int N_GP   = NREG - N_SENS;

    localparam logic [ADDR_W-1:0] IDX_MASK = 3'd0;
    localparam logic [ADDR_W-1:0] IDX_KCTL = 3'd1;
    localparam logic [ADDR_W-1:0] IDX_KVAL = 3'd2;
    localparam logic [ADDR_W-1:0] IDX_KCLR = 3'd3;

    localparam logic [ROLE_W-1:0] ROLE_BOOT = 3'd0;

    localparam logic [NROLE-1:0] MASK_RESET = 5'b00001;

    // Read grants, index 7 down to 0 (dma,dbg,untrusted,trusted,boot).
    localparam logic [NREG-1:0][NROLE-1:0] RD_GRANT = {
        5'b11111, 5'b11111, 5'b01111, 5'b01111,
        5'b00000, 5'b00011, 5'b00001, 5'b00011};
    // Write grants, index 7 down to 0.
    localparam logic [NREG-1:0][NROLE-1:0] WR_GRANT = {
        5'b11011, 5'b11011, 5'b01011, 5'b01011,
        5'b00001, 5'b00001, 5'b00001, 5'b00001};
endpackage

// File: rtl/regacc_policy.sv
// Combinational allow/deny decision.
// Assumes inputs are stable for the sampling edge. Every path is evaluated
// in parallel (one-hot role match), so the decision depth does not depend
// on the outcome.
module regacc_policy
    import regacc_pkg::*;
(
    input  logic              req_write,
    input  logic [ROLE_W-1:0] req_role,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NROLE-1:0]  role_en,
    input  logic              mask_locked,
    input  logic              tamper,
    output logic              allow
);
    logic [NROLE-1:0] role_hot;
    logic [NROLE-1:0] row;
    logic             grant;
    logic             sens_block;
    logic             mask_block;

    // One-hot decode of the role; unknown roles match no bit.
    for (genvar r = 0; r < NROLE; r++) begin : g_role
        assign role_hot[r] = (req_role == ROLE_W'(r));
    end

    // Select the grant row of the addressed register for this direction.
    always_comb begin
        row = req_write ? WR_GRANT[req_addr] : RD_GRANT[req_addr];
    end

    assign grant      = |(row & role_hot & role_en);
    assign sens_block = tamper && (int'(req_addr) < N_SENS);
    assign mask_block = req_write && (req_addr == IDX_MASK) && mask_locked;
    assign allow      = grant && !sens_block && !mask_block;
endmodule

// File: rtl/regacc_bank.sv
// Register storage behind the checker.
// Assumes wr_en is asserted only for granted writes. Holds the write-once
// role-enable mask, the key group and the general words; reads are
// combinational on the index.
module regacc_bank
    import regacc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NROLE-1:0]  role_en,
    output logic              mask_locked,
    output logic [DATA_W-1:0] key_ctrl,
    output logic [DATA_W-1:0] key_valid
);
    logic [NROLE-1:0]  mask_q;
    logic              locked_q;
    logic [DATA_W-1:0] kctl_q;
    logic [DATA_W-1:0] kval_q;
    logic [DATA_W-1:0] gp_q [N_GP];
    logic              clr_hit;

    assign clr_hit = wr_en && (addr == IDX_KCLR) && wdata[0];

    // Role mask: first granted write loads it and locks further writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= MASK_RESET;
            locked_q <= 1'b0;
        end else if (wr_en && addr == IDX_MASK && !locked_q) begin
            mask_q   <= wdata[NROLE-1:0];
            locked_q <= 1'b1;
        end
    end

    // Key control and key valid words, with clear from the key-clear index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kctl_q <= '0;
            kval_q <= '0;
        end else if (clr_hit) begin
            kctl_q <= '0;
            kval_q <= '0;
        end else if (wr_en && addr == IDX_KCTL) begin
            kctl_q <= wdata;
        end else if (wr_en && addr == IDX_KVAL) begin
            kval_q <= wdata;
        end
    end

    // General configuration and buffer words, one register each.
    for (genvar g = 0; g < N_GP; g++) begin : g_gp
        always_ff @(posedge clk) begin
            if (!rst_n) gp_q[g] <= '0;
            else if (wr_en && int'(addr) == N_SENS + g) gp_q[g] <= wdata;
        end
    end

    // Read mux; the key-clear index reads as zero.
    always_comb begin
        rdata = '0;
        case (addr)
            IDX_MASK: rdata = DATA_W'(mask_q);
            IDX_KCTL: rdata = kctl_q;
            IDX_KVAL: rdata = kval_q;
            IDX_KCLR: rdata = '0;
            default:  rdata = gp_q[int'(addr) - N_SENS];
        endcase
    end

    assign role_en     = mask_q;
    assign mask_locked = locked_q;
    assign key_ctrl    = kctl_q;
    assign key_valid   = kval_q;
endmodule

// File: rtl/regacc_guard.sv
// Top of the role-based register access checker.
// Assumes one request per cycle at most and that the role number is
// already trustworthy. Responses are registered: exactly one cycle of
// latency for every request, granted or refused.
module regacc_guard
    import regacc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ROLE_W-1:0] req_role,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              tamper,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              violation,
    output logic [DATA_W-1:0] key_ctrl,
    output logic [DATA_W-1:0] key_valid
);
    logic              allow;
    logic [NROLE-1:0]  role_en;
    logic              mask_locked;
    logic [DATA_W-1:0] bank_rdata;
    logic              deny;

    regacc_policy u_policy (
        .req_write   (req_write),
        .req_role    (req_role),
        .req_addr    (req_addr),
        .role_en     (role_en),
        .mask_locked (mask_locked),
        .tamper      (tamper),
        .allow       (allow)
    );

    regacc_bank #(.DATA_W(DATA_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (req_valid && req_write && allow),
        .addr        (req_addr),
        .wdata       (req_wdata),
        .rdata       (bank_rdata),
        .role_en     (role_en),
        .mask_locked (mask_locked),
        .key_ctrl    (key_ctrl),
        .key_valid   (key_valid)
    );

    assign deny = req_valid && !allow;

    // Response register: valid, error flag and masked read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= deny;
            rsp_rdata <= (req_valid && !req_write && allow) ? bank_rdata : '0;
        end
    end

    // Sticky violation flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) violation <= 1'b0;
        else if (deny) violation <= 1'b1;
    end
endmodule

// File: rtl/regacc_guard_chk.sv
// Property checker for regacc_guard, attached by bind below.
// Assumes requests are sampled at the rising edge with stable inputs.
module regacc_guard_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [2:0]        req_role,
    input logic [2:0]        req_addr,
    input logic              tamper,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              violation,
    input logic [DATA_W-1:0] key_ctrl
);
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_err_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));
    assert_unknown_role_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_role > 3'd4) |=> rsp_err);
    assert_untrusted_keys_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_role == 3'd2 && req_addr >= 3'd1 && req_addr <= 3'd3)
        |=> rsp_err);
    assert_dma_bufonly_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_role == 3'd4 && req_addr < 3'd6) |=> rsp_err);
    assert_tamper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && tamper && req_addr < 3'd4) |=> rsp_err);
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);
    assert_err_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> violation);
    assert_key_guarded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key_ctrl) |-> $past(req_valid && req_write && req_role == 3'd0
                                    && !tamper
                                    && (req_addr == 3'd1 || req_addr == 3'd3)));
endmodule

bind regacc_guard regacc_guard_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_role  (req_role),
    .req_addr  (req_addr),
    .tamper    (tamper),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .violation (violation),
    .key_ctrl  (key_ctrl)
);

// File: tb/regacc_guard_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked by one loop, then directed
// checks on reset, idle latency, the sticky flag and key outputs.
module regacc_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_role = '0;
    logic [2:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        tamper = 1'b0;
    logic        rsp_valid, rsp_err, violation;
    logic [31:0] rsp_rdata, key_ctrl, key_valid;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    regacc_guard u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_role(req_role), .req_addr(req_addr), .req_wdata(req_wdata),
        .tamper(tamper), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .violation(violation),
        .key_ctrl(key_ctrl), .key_valid(key_valid)
    );

    typedef struct packed {
        logic        w;
        logic [2:0]  role;
        logic [2:0]  addr;
        logic [31:0] wd;
        logic        tmp;
        logic        err;
        logic [31:0] rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 31;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 3'd1, 3'd2, 32'h0,        1'b0, 1'b1, 32'h0,        4'd6},  // R6 trusted masked off
        '{1'b1, 3'd0, 3'd0, 32'h1F,       1'b0, 1'b0, 32'h0,        4'd6},  // R6 first mask write
        '{1'b1, 3'd0, 3'd0, 32'h01,       1'b0, 1'b1, 32'h0,        4'd6},  // R6 second write refused
        '{1'b0, 3'd0, 3'd0, 32'h0,        1'b0, 1'b0, 32'h1F,       4'd6},  // R6 mask kept
        '{1'b1, 3'd0, 3'd1, 32'hA5A50001, 1'b0, 1'b0, 32'h0,        4'd4},  // R4 boot writes key ctrl
        '{1'b0, 3'd0, 3'd1, 32'h0,        1'b0, 1'b0, 32'hA5A50001, 4'd4},  // R4
        '{1'b1, 3'd0, 3'd2, 32'h1,        1'b0, 1'b0, 32'h0,        4'd4},  // R4 boot writes key valid
        '{1'b0, 3'd1, 3'd2, 32'h0,        1'b0, 1'b0, 32'h1,        4'd4},  // R4 trusted reads key valid
        '{1'b1, 3'd1, 3'd1, 32'hDEAD,     1'b0, 1'b1, 32'h0,        4'd4},  // R4 trusted write key ctrl refused
        '{1'b0, 3'd0, 3'd1, 32'h0,        1'b0, 1'b0, 32'hA5A50001, 4'd3},  // R3 unchanged
        '{1'b0, 3'd2, 3'd2, 32'h0,        1'b0, 1'b1, 32'h0,        4'd4},  // R4 untrusted read refused
        '{1'b1, 3'd2, 3'd3, 32'h1,        1'b0, 1'b1, 32'h0,        4'd4},  // R4 untrusted clear refused
        '{1'b0, 3'd0, 3'd2, 32'h0,        1'b0, 1'b0, 32'h1,        4'd3},  // R3 key valid intact
        '{1'b1, 3'd4, 3'd6, 32'h1234,     1'b0, 1'b0, 32'h0,        4'd5},  // R5 dma buffer write
        '{1'b0, 3'd4, 3'd6, 32'h0,        1'b0, 1'b0, 32'h1234,     4'd5},  // R5 dma buffer read
        '{1'b0, 3'd4, 3'd4, 32'h0,        1'b0, 1'b1, 32'h0,        4'd5},  // R5 dma config read refused
        '{1'b1, 3'd4, 3'd4, 32'h9,        1'b0, 1'b1, 32'h0,        4'd5},  // R5 dma config write refused
        '{1'b0, 3'd5, 3'd6, 32'h0,        1'b0, 1'b1, 32'h0,        4'd1},  // R1 role 5 refused
        '{1'b1, 3'd7, 3'd7, 32'h7,        1'b0, 1'b1, 32'h0,        4'd1},  // R1 role 7 refused
        '{1'b1, 3'd3, 3'd5, 32'h55,       1'b0, 1'b0, 32'h0,        4'd1},  // R1 debug grant
        '{1'b0, 3'd2, 3'd5, 32'h0,        1'b0, 1'b0, 32'h55,       4'd1},  // R1 untrusted read grant
        '{1'b1, 3'd2, 3'd5, 32'h66,       1'b0, 1'b1, 32'h0,        4'd3},  // R3 refused write
        '{1'b0, 3'd0, 3'd5, 32'h0,        1'b0, 1'b0, 32'h55,       4'd3},  // R3 config intact
        '{1'b0, 3'd0, 3'd1, 32'h0,        1'b1, 1'b1, 32'h0,        4'd7},  // R7 tamper read
        '{1'b1, 3'd0, 3'd1, 32'h0,        1'b1, 1'b1, 32'h0,        4'd7},  // R7 tamper write
        '{1'b0, 3'd0, 3'd6, 32'h0,        1'b1, 1'b0, 32'h1234,     4'd7},  // R7 buffer unaffected
        '{1'b0, 3'd0, 3'd1, 32'h0,        1'b0, 1'b0, 32'hA5A50001, 4'd7},  // R7 access returns
        '{1'b0, 3'd0, 3'd3, 32'h0,        1'b0, 1'b1, 32'h0,        4'd10}, // R10 clear index unreadable
        '{1'b1, 3'd0, 3'd3, 32'h1,        1'b0, 1'b0, 32'h0,        4'd10}, // R10 clear keys
        '{1'b0, 3'd0, 3'd1, 32'h0,        1'b0, 1'b0, 32'h0,        4'd10}, // R10 key ctrl zero
        '{1'b0, 3'd0, 3'd2, 32'h0,        1'b0, 1'b0, 32'h0,        4'd10}  // R10 key valid zero
    };

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request: drive on falling edge, sample response one cycle later.
    task automatic txn(input logic w, input logic [2:0] role, input logic [2:0] addr,
                       input logic [31:0] wd, input logic tmp,
                       input logic err, input logic [31:0] rd, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_role = role;
        req_addr = addr; req_wdata = wd; tamper = tmp;
        @(negedge clk);
        req_valid = 1'b0; tamper = 1'b0;
        check(rsp_valid === 1'b1 && rsp_err === err && rsp_rdata === rd, tag,
              {31'd0, rsp_valid, rsp_err, rsp_rdata}, {31'd0, 1'b1, err, rd});
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(rsp_valid === 0 && rsp_err === 0 && violation === 0, "R11 reset flags",
              {61'd0, rsp_valid, rsp_err, violation}, 64'd0);
        check(key_ctrl === 0 && key_valid === 0, "R11 reset keys",
              {key_ctrl, key_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(violation === 0, "R9 clear before refusal", {63'd0, violation}, 64'd0);

        for (int i = 0; i < NVEC; i++) begin
            txn(VEC[i].w, VEC[i].role, VEC[i].addr, VEC[i].wd, VEC[i].tmp,
                VEC[i].err, VEC[i].rd, $sformatf("R%0d vector %0d", VEC[i].req, i));
        end

        // R8 no response in an idle cycle
        @(negedge clk);
        check(rsp_valid === 0, "R8 idle response", {63'd0, rsp_valid}, 64'd0);
        // R10 key outputs cleared at the ports
        check(key_ctrl === 0 && key_valid === 0, "R10 key ports",
              {key_ctrl, key_valid}, 64'd0);
        // R9 flag still set after granted traffic
        txn(1'b0, 3'd0, 3'd6, 32'h0, 1'b0, 1'b0, 32'h1234, "R2 granted read no error");
        check(violation === 1, "R9 sticky", {63'd0, violation}, 64'd1);

        // Reset again: flag cleared, mask back to boot only
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(violation === 0 && rsp_valid === 0, "R9 reset clears flag",
              {62'd0, violation, rsp_valid}, 64'd0);
        txn(1'b0, 3'd0, 3'd6, 32'h0, 1'b0, 1'b0, 32'h0, "R11 buffer zero after reset");
        check(violation === 0, "R9 granted keeps flag low", {63'd0, violation}, 64'd0);
        txn(1'b0, 3'd1, 3'd4, 32'h0, 1'b0, 1'b1, 32'h0, "R6 mask reset to boot only");
        txn(1'b1, 3'd0, 3'd0, 32'h03, 1'b0, 1'b0, 32'h0, "R6 fresh write after reset");
        txn(1'b0, 3'd1, 3'd4, 32'h0, 1'b0, 1'b0, 32'h0, "R6 trusted enabled");
        txn(1'b0, 3'd2, 3'd4, 32'h0, 1'b0, 1'b1, 32'h0, "R6 untrusted still off");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule